// File: doc/BRIEF.md
# Type-C Lane Crossbar Change Sequencer

This block takes a connection change for a USB/DisplayPort lane crossbar and carries it out in a safe order. Software-style inputs present a 2-bit connection mode, a plug orientation, a low-power flag and a one-cycle write strobe. The block latches the fields into a pending slot, raises a pending flag, and clears that flag itself once its sequencer has taken the request.

The sequencer first quiesces the controllers that the present crossbar mode uses. For each such controller it can raise a disable request and wait for the acknowledge, and it always waits until that controller's lanes report a parked power state. It then rewrites the crossbar mode and orientation, optionally wrapping the rewrite in a transient crossbar disable. It drops the disable requests of the controllers the new mode uses, and reports completion with a one-cycle pulse. A request that stalls longer than a programmable limit is abandoned with a timeout pulse, and the crossbar is left unchanged.

Top module: `typec_mux_seq`

## Requirements
- R1: Connection modes are 2'b00 none, 2'b01 USB only, 2'b10 DP on all lanes, and 2'b11 USB plus DP on the lower half of the DP lanes. Bit 0 marks USB use and bit 1 marks DP use. After a completed request, `xbar_mode` equals the requested mode, and the crossbar outputs change only while `busy` is high.
- R2: A `wr_valid` strobe while idle sets `req_pending` on the next edge, and the block clears it on the following edge. A strobe while `busy` or `req_pending` is high is ignored.
- R3: On completion, `xbar_flip` equals the requested orientation XOR `flip_invert`.
- R4: If the current mode uses USB and `cfg_usb_handshake` is 1, `usb_quiesce_req` goes high and the switch waits for `usb_quiesce_ack` and for both USB lane states to be parked. With the handshake off, it waits for the lane states only. Lane state 2'b11 is P3 and 2'b10 is P2.
- R5: If the current mode uses DP, the switch waits for every active DP lane to be parked: all lanes in mode 2'b10, and only the lower half in mode 2'b11. With `cfg_dp_handshake` set, it also raises `dp_quiesce_req` and waits for `dp_quiesce_ack`.
- R6: P3 always counts as parked. P2 counts as parked for USB lanes only when `cfg_usb_p2_ok` is 1, and for DP lanes only when `cfg_dp_p2_ok` is 1.
- R7: With `cfg_auto_safe` set and the low-power flag clear, `xbar_disable` is high in the cycle the mode or flip changes, and it is low again before completion.
- R8: A low-power request ends with `xbar_disable` high. Any other request ends with it low.
- R9: `block_ss` goes high at quiesce when leaving mode 2'b01 with `cfg_auto_block[0]` set, or when leaving mode 2'b11 with `cfg_auto_block[1]` set. It is cleared when a completed request's new mode uses USB.
- R10: A stall longer than `cfg_timeout_units` × 256 cycles raises `evt_timeout` for one cycle, returns the block to idle and leaves the crossbar outputs unchanged. A limit of 0 disables the timeout.
- R11: Completion raises `evt_ack` for one cycle while the block is idle. `evt_ack` and `evt_timeout` are never high together.
- R12: At completion, each quiesce request is dropped if the new mode uses that controller and is held high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Request write strobe |
| wr_mode | input | 2 | Requested connection mode |
| wr_flip | input | 1 | Requested plug orientation |
| wr_low_power | input | 1 | Request low-power safe state |
| flip_invert | input | 1 | Inverts the orientation sense |
| cfg_usb_handshake | input | 1 | Use the USB quiesce handshake |
| cfg_dp_handshake | input | 1 | Use the DP quiesce handshake |
| cfg_usb_p2_ok | input | 1 | USB lanes may switch from P2 |
| cfg_dp_p2_ok | input | 1 | DP lanes may switch from P2 |
| cfg_auto_safe | input | 1 | Wrap the switch in a transient disable |
| cfg_auto_block | input | 2 | Auto SuperSpeed block when leaving modes 01 / 11 |
| cfg_timeout_units | input | LIM_W | Timeout limit in 256-cycle units |
| usb_quiesce_ack | input | 1 | USB controller acknowledge |
| dp_quiesce_ack | input | 1 | DP controller acknowledge |
| usb_tx_pstate | input | 2 | USB TX lane power state |
| usb_rx_pstate | input | 2 | USB RX lane power state |
| dp_tx_pstate | input | 2*DP_LANES | DP TX lane power states, lane i at [2i+1:2i] |
| req_pending | output | 1 | Pending-request flag |
| busy | output | 1 | Sequence in progress |
| xbar_mode | output | 2 | Crossbar connection mode |
| xbar_flip | output | 1 | Crossbar orientation |
| xbar_disable | output | 1 | Crossbar disable / safe state |
| block_ss | output | 1 | SuperSpeed operation blocked |
| usb_quiesce_req | output | 1 | USB controller disable request |
| dp_quiesce_req | output | 1 | DP controller disable request |
| evt_ack | output | 1 | Completion pulse |
| evt_timeout | output | 1 | Timeout pulse |

## Verification
Two functions can fall in the same cycle: the completion pulse of one request and the write strobe of the next. The bench drives a new strobe in exactly the cycle in which `evt_ack` is seen. Because the block is idle in that cycle, the strobe must be accepted, and a second completion must follow with the new mode. A strobe placed inside a stalled sequence is the contrasting case: it must leave `req_pending` low and must not change the outcome of the request already running.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUIESCE,
    ST_WAIT,
    ST_SAFE_ON,
    ST_APPLY,
    ST_SAFE_OFF,
    ST_RELEASE
  } seq_st_t;

  localparam logic [1:0] MUX_NONE    = 2'b00;
  localparam logic [1:0] MUX_USB     = 2'b01;
  localparam logic [1:0] MUX_DP_ALL  = 2'b10;
  localparam logic [1:0] MUX_USB_DP  = 2'b11;

  localparam logic [1:0] PS_P3 = 2'b11;
  localparam logic [1:0] PS_P2 = 2'b10;

  function automatic logic mode_has_usb(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_has_dp(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic lane_parked(input logic [1:0] ps, input logic p2_ok);
    return (ps == PS_P3) || (p2_ok && (ps == PS_P2));
  endfunction

endpackage

// File: rtl/tcs_req_latch.sv
module tcs_req_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  input  logic [1:0] wr_mode,
  input  logic       wr_flip,
  input  logic       wr_low_power,
  input  logic       locked,
  input  logic       take,
  output logic       pending,
  output logic [1:0] hold_mode,
  output logic       hold_flip,
  output logic       hold_low_power
);
  logic accept;
  assign accept = wr_valid && !locked && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending        <= 1'b0;
      hold_mode      <= 2'b00;
      hold_flip      <= 1'b0;
      hold_low_power <= 1'b0;
    end else begin
      if (accept) begin
        pending        <= 1'b1;
        hold_mode      <= wr_mode;
        hold_flip      <= wr_flip;
        hold_low_power <= wr_low_power;
      end else if (take) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcs_lane_gate.sv
module tcs_lane_gate #(
  parameter int DP_LANES = 4
) (
  input  logic [1:0]            live_mode,
  input  logic [1:0]            usb_tx_ps,
  input  logic [1:0]            usb_rx_ps,
  input  logic [2*DP_LANES-1:0] dp_ps,
  input  logic                  usb_p2_ok,
  input  logic                  dp_p2_ok,
  input  logic                  usb_hs_en,
  input  logic                  dp_hs_en,
  input  logic                  usb_ack,
  input  logic                  dp_ack,
  output logic                  gate_open
);
  import tcs_pkg::*;

  localparam int SHARED = DP_LANES / 2;

  logic [DP_LANES-1:0] lane_ok;
  logic usb_ok, dp_ok;

  generate
    for (genvar i = 0; i < DP_LANES; i++) begin : g_dp
      localparam bit IN_SHARED = (i < SHARED);
      logic active;
      if (IN_SHARED) begin : g_low
        assign active = (live_mode == MUX_DP_ALL) || (live_mode == MUX_USB_DP);
      end else begin : g_high
        assign active = (live_mode == MUX_DP_ALL);
      end
      assign lane_ok[i] = !active || lane_parked(dp_ps[2*i +: 2], dp_p2_ok);
    end
  endgenerate

  assign usb_ok = !mode_has_usb(live_mode) ||
                  (lane_parked(usb_tx_ps, usb_p2_ok) &&
                   lane_parked(usb_rx_ps, usb_p2_ok) &&
                   (!usb_hs_en || usb_ack));

  assign dp_ok = !mode_has_dp(live_mode) ||
                 ((&lane_ok) && (!dp_hs_en || dp_ack));

  assign gate_open = usb_ok && dp_ok;
endmodule

// File: rtl/tcs_timeout.sv
module tcs_timeout #(
  parameter int PRE_W = 8,
  parameter int LIM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);
  logic [PRE_W-1:0] pre;
  logic [LIM_W-1:0] units;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre   <= '0;
      units <= '0;
    end else if (run) begin
      if (pre == {PRE_W{1'b1}}) begin
        pre <= '0;
        if (units != {LIM_W{1'b1}}) units <= units + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = (limit != '0) && (units >= limit);
endmodule

// File: rtl/typec_mux_seq.sv
module typec_mux_seq #(
  parameter int DP_LANES = 4,
  parameter int PRE_W    = 8,
  parameter int LIM_W    = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic [1:0]            wr_mode,
  input  logic                  wr_flip,
  input  logic                  wr_low_power,
  input  logic                  flip_invert,
  input  logic                  cfg_usb_handshake,
  input  logic                  cfg_dp_handshake,
  input  logic                  cfg_usb_p2_ok,
  input  logic                  cfg_dp_p2_ok,
  input  logic                  cfg_auto_safe,
  input  logic [1:0]            cfg_auto_block,
  input  logic [LIM_W-1:0]      cfg_timeout_units,
  input  logic                  usb_quiesce_ack,
  input  logic                  dp_quiesce_ack,
  input  logic [1:0]            usb_tx_pstate,
  input  logic [1:0]            usb_rx_pstate,
  input  logic [2*DP_LANES-1:0] dp_tx_pstate,
  output logic                  req_pending,
  output logic                  busy,
  output logic [1:0]            xbar_mode,
  output logic                  xbar_flip,
  output logic                  xbar_disable,
  output logic                  block_ss,
  output logic                  usb_quiesce_req,
  output logic                  dp_quiesce_req,
  output logic                  evt_ack,
  output logic                  evt_timeout
);
  import tcs_pkg::*;

  seq_st_t    state;
  logic       take;
  logic [1:0] hold_mode;
  logic       hold_flip, hold_low_power;
  logic [1:0] tgt_mode;
  logic       tgt_flip, tgt_low_power, wrap;
  logic       gate_open, expired, tmr_clear, tmr_run;

  assign busy      = (state != ST_IDLE);
  assign take      = (state == ST_IDLE) && req_pending;
  assign tmr_clear = (state != ST_WAIT);
  assign tmr_run   = (state == ST_WAIT);

  tcs_req_latch u_latch (
    .clk            (clk),
    .rst            (rst),
    .wr_valid       (wr_valid),
    .wr_mode        (wr_mode),
    .wr_flip        (wr_flip),
    .wr_low_power   (wr_low_power),
    .locked         (busy),
    .take           (take),
    .pending        (req_pending),
    .hold_mode      (hold_mode),
    .hold_flip      (hold_flip),
    .hold_low_power (hold_low_power)
  );

  tcs_lane_gate #(.DP_LANES(DP_LANES)) u_gate (
    .live_mode (xbar_mode),
    .usb_tx_ps (usb_tx_pstate),
    .usb_rx_ps (usb_rx_pstate),
    .dp_ps     (dp_tx_pstate),
    .usb_p2_ok (cfg_usb_p2_ok),
    .dp_p2_ok  (cfg_dp_p2_ok),
    .usb_hs_en (cfg_usb_handshake),
    .dp_hs_en  (cfg_dp_handshake),
    .usb_ack   (usb_quiesce_ack),
    .dp_ack    (dp_quiesce_ack),
    .gate_open (gate_open)
  );

  tcs_timeout #(.PRE_W(PRE_W), .LIM_W(LIM_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .limit   (cfg_timeout_units),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      tgt_mode        <= MUX_NONE;
      tgt_flip        <= 1'b0;
      tgt_low_power   <= 1'b0;
      wrap            <= 1'b0;
      xbar_mode       <= MUX_NONE;
      xbar_flip       <= 1'b0;
      xbar_disable    <= 1'b0;
      block_ss        <= 1'b0;
      usb_quiesce_req <= 1'b0;
      dp_quiesce_req  <= 1'b0;
      evt_ack         <= 1'b0;
      evt_timeout     <= 1'b0;
    end else begin
      evt_ack     <= 1'b0;
      evt_timeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            tgt_mode      <= hold_mode;
            tgt_flip      <= hold_flip;
            tgt_low_power <= hold_low_power;
            state         <= ST_QUIESCE;
          end
        end
        ST_QUIESCE: begin
          if (mode_has_usb(xbar_mode) && cfg_usb_handshake) usb_quiesce_req <= 1'b1;
          if (mode_has_dp(xbar_mode) && cfg_dp_handshake)   dp_quiesce_req  <= 1'b1;
          if ((xbar_mode == MUX_USB && tgt_mode != MUX_USB && cfg_auto_block[0]) ||
              (xbar_mode == MUX_USB_DP && tgt_mode != MUX_USB_DP && cfg_auto_block[1]))
            block_ss <= 1'b1;
          wrap  <= cfg_auto_safe && !tgt_low_power;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (gate_open) begin
            state <= wrap ? ST_SAFE_ON : ST_APPLY;
          end else if (expired) begin
            evt_timeout <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_SAFE_ON: begin
          xbar_disable <= 1'b1;
          state        <= ST_APPLY;
        end
        ST_APPLY: begin
          xbar_mode    <= tgt_mode;
          xbar_flip    <= tgt_flip ^ flip_invert;
          xbar_disable <= tgt_low_power | wrap;
          state        <= wrap ? ST_SAFE_OFF : ST_RELEASE;
        end
        ST_SAFE_OFF: begin
          xbar_disable <= 1'b0;
          state        <= ST_RELEASE;
        end
        ST_RELEASE: begin
          if (mode_has_usb(tgt_mode)) begin
            usb_quiesce_req <= 1'b0;
            block_ss        <= 1'b0;
          end
          if (mode_has_dp(tgt_mode)) dp_quiesce_req <= 1'b0;
          evt_ack <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_pending,
  input logic       busy,
  input logic [1:0] xbar_mode,
  input logic       xbar_flip,
  input logic       block_ss,
  input logic       usb_quiesce_req,
  input logic       evt_ack,
  input logic       evt_timeout
);
  assert_no_dual_event_R11: assert property (@(posedge clk) disable iff (rst)
    !(evt_ack && evt_timeout));

  assert_ack_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    evt_ack |-> !busy);

  assert_pending_autoclear_R2: assert property (@(posedge clk) disable iff (rst)
    req_pending |=> !req_pending);

  assert_mode_moves_in_seq_R1: assert property (@(posedge clk) disable iff (rst)
    (xbar_mode != $past(xbar_mode)) |-> busy);

  assert_timeout_keeps_xbar_R10: assert property (@(posedge clk) disable iff (rst)
    evt_timeout |-> (xbar_mode == $past(xbar_mode)) && (xbar_flip == $past(xbar_flip)));

  assert_usb_release_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(usb_quiesce_req) |-> xbar_mode[0]);

  assert_block_in_seq_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(block_ss) |-> busy);
endmodule

bind typec_mux_seq tcs_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_pending     (req_pending),
  .busy            (busy),
  .xbar_mode       (xbar_mode),
  .xbar_flip       (xbar_flip),
  .block_ss        (block_ss),
  .usb_quiesce_req (usb_quiesce_req),
  .evt_ack         (evt_ack),
  .evt_timeout     (evt_timeout)
);

// File: tb/tb_typec_mux_seq.sv
module tb_typec_mux_seq;
  localparam int DP_LANES = 4;
  localparam int LIM_W    = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, wr_flip = 1'b0, wr_low_power = 1'b0, flip_invert = 1'b0;
  logic [1:0] wr_mode = 2'b00;
  logic cfg_usb_handshake = 1'b0, cfg_dp_handshake = 1'b0;
  logic cfg_usb_p2_ok = 1'b0, cfg_dp_p2_ok = 1'b0, cfg_auto_safe = 1'b0;
  logic [1:0] cfg_auto_block = 2'b00;
  logic [LIM_W-1:0] cfg_timeout_units = '0;
  logic usb_quiesce_ack = 1'b0, dp_quiesce_ack = 1'b0;
  logic [1:0] usb_tx_pstate = 2'b11, usb_rx_pstate = 2'b11;
  logic [2*DP_LANES-1:0] dp_tx_pstate = '1;
  logic req_pending, busy, xbar_flip, xbar_disable, block_ss;
  logic usb_quiesce_req, dp_quiesce_req, evt_ack, evt_timeout;
  logic [1:0] xbar_mode;

  int checks = 0, errors = 0;
  int safe_chg = 0, unsafe_chg = 0;
  logic [1:0] prev_mode = 2'b00;
  logic prev_flip = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  typec_mux_seq #(.DP_LANES(DP_LANES), .LIM_W(LIM_W)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_mode(wr_mode), .wr_flip(wr_flip),
    .wr_low_power(wr_low_power), .flip_invert(flip_invert),
    .cfg_usb_handshake(cfg_usb_handshake), .cfg_dp_handshake(cfg_dp_handshake),
    .cfg_usb_p2_ok(cfg_usb_p2_ok), .cfg_dp_p2_ok(cfg_dp_p2_ok),
    .cfg_auto_safe(cfg_auto_safe), .cfg_auto_block(cfg_auto_block),
    .cfg_timeout_units(cfg_timeout_units), .usb_quiesce_ack(usb_quiesce_ack),
    .dp_quiesce_ack(dp_quiesce_ack), .usb_tx_pstate(usb_tx_pstate),
    .usb_rx_pstate(usb_rx_pstate), .dp_tx_pstate(dp_tx_pstate),
    .req_pending(req_pending), .busy(busy), .xbar_mode(xbar_mode),
    .xbar_flip(xbar_flip), .xbar_disable(xbar_disable), .block_ss(block_ss),
    .usb_quiesce_req(usb_quiesce_req), .dp_quiesce_req(dp_quiesce_req),
    .evt_ack(evt_ack), .evt_timeout(evt_timeout)
  );

  // Monitor: crossbar changes with and without the disable held high (R7)
  always @(negedge clk) begin
    if (!rst) begin
      if (xbar_mode != prev_mode || xbar_flip != prev_flip) begin
        if (xbar_disable) safe_chg++;
        else unsafe_chg++;
      end
      prev_mode = xbar_mode;
      prev_flip = xbar_flip;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic f, input logic lp);
    @(negedge clk);
    wr_valid = 1'b1; wr_mode = m; wr_flip = f; wr_low_power = lp;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_evt(input int maxc, output logic got_ack, output logic got_to, output int n);
    got_ack = 1'b0; got_to = 1'b0; n = 0;
    while (!got_ack && !got_to && n < maxc) begin
      @(negedge clk);
      n++;
      if (evt_ack) got_ack = 1'b1;
      if (evt_timeout) got_to = 1'b1;
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset mode", xbar_mode, 2'b00);
    chk("R8 reset disable", xbar_disable, 0);
    chk("R12 reset quiesce reqs", {usb_quiesce_req, dp_quiesce_req}, 0);
    chk("R2 reset pending/busy", {req_pending, busy}, 0);
    chk("R9 reset block", block_ss, 0);
  endtask

  task automatic t_connect_usb;
    logic a, t; int n;
    send(2'b01, 1'b1, 1'b0);
    chk("R2 pending set", req_pending, 1);
    @(negedge clk);
    chk("R2 pending self-clear", req_pending, 0);
    wait_evt(50, a, t, n);
    chk("R11 ack seen", a, 1);
    chk("R1 mode usb", xbar_mode, 2'b01);
    chk("R3 flip plain", xbar_flip, 1);
    chk("R8 disable low", xbar_disable, 0);
  endtask

  task automatic t_flip_invert;
    logic a, t; int n;
    flip_invert = 1'b1;
    send(2'b01, 1'b1, 1'b0);
    wait_evt(50, a, t, n);
    chk("R3 flip inverted", xbar_flip, 0);
    flip_invert = 1'b0;
  endtask

  task automatic t_usb_handshake;
    logic a, t; int n;
    cfg_usb_handshake = 1'b1; cfg_auto_block = 2'b01;
    usb_tx_pstate = 2'b00; usb_rx_pstate = 2'b00;
    send(2'b10, 1'b0, 1'b0);
    idle(10);
    chk("R4 usb req raised", usb_quiesce_req, 1);
    chk("R9 block on leaving usb", block_ss, 1);
    chk("R4 waits for P3", {busy, xbar_mode}, {1'b1, 2'b01});
    usb_tx_pstate = 2'b11; usb_rx_pstate = 2'b11;
    idle(10);
    chk("R4 waits for ack", busy, 1);
    usb_quiesce_ack = 1'b1;
    wait_evt(50, a, t, n);
    chk("R4 completes on ack", {a, xbar_mode}, {1'b1, 2'b10});
    chk("R12 usb req held", usb_quiesce_req, 1);
    usb_quiesce_ack = 1'b0;
  endtask

  task automatic t_dp_lanes;
    logic a, t; int n;
    dp_tx_pstate = 8'b10_11_11_11;
    send(2'b11, 1'b0, 1'b0);
    idle(10);
    chk("R5 lane3 blocks in dp-all", {busy, xbar_mode}, {1'b1, 2'b10});
    cfg_dp_p2_ok = 1'b1;
    wait_evt(50, a, t, n);
    chk("R6 P2 accepted", {a, xbar_mode}, {1'b1, 2'b11});
    chk("R12 usb req dropped", usb_quiesce_req, 0);
    chk("R9 block cleared", block_ss, 0);
    cfg_dp_p2_ok = 1'b0;
  endtask

  task automatic t_dp_handshake;
    logic a, t; int n;
    cfg_usb_handshake = 1'b0; cfg_dp_handshake = 1'b1; cfg_auto_block = 2'b10;
    dp_tx_pstate = 8'b00_00_11_11;
    send(2'b01, 1'b0, 1'b0);
    idle(10);
    chk("R5 dp req raised", dp_quiesce_req, 1);
    chk("R9 block on leaving usb+dp", block_ss, 1);
    chk("R5 waits for dp ack", busy, 1);
    dp_quiesce_ack = 1'b1;
    wait_evt(50, a, t, n);
    chk("R5 upper lanes ignored in shared mode", {a, xbar_mode}, {1'b1, 2'b01});
    chk("R12 dp req held", dp_quiesce_req, 1);
    chk("R9 block cleared for usb", block_ss, 0);
    dp_quiesce_ack = 1'b0; cfg_dp_handshake = 1'b0; cfg_auto_block = 2'b00;
  endtask

  task automatic t_safe_wrap;
    logic a, t; int n;
    cfg_auto_safe = 1'b1;
    safe_chg = 0; unsafe_chg = 0;
    send(2'b11, 1'b1, 1'b0);
    wait_evt(50, a, t, n);
    chk("R7 change under disable", safe_chg, 1);
    chk("R7 no unguarded change", unsafe_chg, 0);
    chk("R7 disable released", xbar_disable, 0);
    chk("R12 dp req dropped", dp_quiesce_req, 0);
  endtask

  task automatic t_low_power;
    logic a, t; int n;
    send(2'b00, 1'b0, 1'b1);
    wait_evt(50, a, t, n);
    chk("R8 low power keeps disable", {a, xbar_disable, xbar_mode}, {1'b1, 1'b1, 2'b00});
    cfg_auto_safe = 1'b0;
    send(2'b01, 1'b0, 1'b0);
    wait_evt(50, a, t, n);
    chk("R8 normal clears disable", {xbar_disable, xbar_mode}, {1'b0, 2'b01});
  endtask

  task automatic t_busy_ignore;
    logic a, t; int n;
    usb_tx_pstate = 2'b00;
    send(2'b10, 1'b0, 1'b0);
    idle(3);
    send(2'b11, 1'b1, 1'b0);
    chk("R2 strobe ignored while busy", req_pending, 0);
    usb_tx_pstate = 2'b11;
    wait_evt(50, a, t, n);
    chk("R2 first request wins", xbar_mode, 2'b10);
    idle(5);
    chk("R2 no second sequence", {busy, req_pending}, 0);
    dp_tx_pstate = '1;
  endtask

  task automatic t_coincide;
    logic a, t; int n;
    send(2'b01, 1'b0, 1'b0);
    n = 0;
    while (!evt_ack && n < 50) begin @(negedge clk); n++; end
    chk("R11 ack pulse", evt_ack, 1);
    wr_valid = 1'b1; wr_mode = 2'b00; wr_flip = 1'b0; wr_low_power = 1'b0;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R11 ack is one cycle", evt_ack, 0);
    chk("R2 strobe in ack cycle accepted", req_pending, 1);
    wait_evt(50, a, t, n);
    chk("R1 back-to-back mode", {a, xbar_mode}, {1'b1, 2'b00});
  endtask

  task automatic t_timeout;
    logic a, t; int n;
    send(2'b01, 1'b0, 1'b0);
    wait_evt(50, a, t, n);
    cfg_usb_handshake = 1'b1; cfg_timeout_units = '0;
    send(2'b10, 1'b1, 1'b0);
    wait_evt(700, a, t, n);
    chk("R10 limit zero never expires", {a, t, busy}, {1'b0, 1'b0, 1'b1});
    cfg_timeout_units = 2;
    wait_evt(20, a, t, n);
    chk("R10 expiry event", {a, t}, {1'b0, 1'b1});
    chk("R10 crossbar unchanged", {xbar_mode, xbar_flip, busy}, {2'b01, 1'b0, 1'b0});
    send(2'b10, 1'b1, 1'b0);
    wait_evt(2000, a, t, n);
    checks++;
    if (!t || a || n < 500 || n > 530) begin
      errors++;
      $display("FAIL R10 timeout latency actual=%0d expected=512..530", n);
    end
    chk("R10 mode kept after timed expiry", xbar_mode, 2'b01);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_connect_usb;
    t_flip_invert;
    t_usb_handshake;
    t_dp_lanes;
    t_dp_handshake;
    t_safe_wrap;
    t_low_power;
    t_busy_ignore;
    t_coincide;
    t_timeout;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule